// File: doc/BRIEF.md
# SMM Memory Steering and Cache Flush Controller

This block sits on the system side of a processor that supports a system management mode (SMM). It watches the CPU's active-low SMM-active indication, brings it into the local clock domain, and uses it for two jobs. The first is steering each memory cycle to one of two chip selects: the store that holds the management handler (SMRAM) or ordinary main memory. The second is issuing an active-low cache flush request when the management session starts and ends. That request drives both the CPU's internal cache and an external second-level cache.

Two layouts are supported, chosen by a configuration input. In the overlaid layout, the SMRAM window shadows part of main memory. The default window is 38000h to 3FFFFh. In this layout the same address reaches SMRAM only for CPU cycles during SMM, and the caches are flushed at SMM entry. They are flushed again at exit unless the cache-enable input showed caching turned off during the entry flush. In the non-overlaid layout, SMRAM has an address window of its own and no flush is ever issued. The window base and the layout are frozen for the whole session. After the exit flush, a status output and a hold on both chip selects keep memory cycles off the bus until the flush completes.

Top module: `smm_mem_steer`

## Requirements
- R1: The window is hit when address bits [ADDR_W-1:WIN_LG] equal the same bits of the captured base. With defaults (WIN_LG=15) and base 38000h, the window covers byte addresses 38000h to 3FFFFh, and 37FFFh and 40000h are outside it.
- R2: With mem_req high and no exit flush busy, a CPU cycle (mem_from_cpu=1) hitting the window during synchronized SMM asserts smram_cs and not main_cs.
- R3: In overlaid mode (cfg_overlay=1), a window hit from a non-CPU master, or any window hit outside SMM, asserts main_cs and never smram_cs.
- R4: A requested cycle outside the window asserts main_cs. With mem_req low, both chip selects are low.
- R5: In non-overlaid mode (cfg_overlay=0), a window hit that is not a CPU cycle during SMM asserts neither chip select.
- R6: In overlaid mode, flush_n goes low for exactly PULSE_CLKS cycles at SMM entry. If smi_act_n is first sampled low at clock edge 1, flush_n is low after edges 3 through 2+PULSE_CLKS.
- R7: In overlaid mode, when caching stayed enabled, the same pulse occurs at SMM exit, counted from the first edge that samples smi_act_n high.
- R8: If cache_en_n is sampled high at any edge during the entry flush, no exit flush is issued for that session. The flag is cleared when the next session starts.
- R9: In non-overlaid mode, flush_n stays high on both edges of SMM-active.
- R10: cfg_overlay and cfg_base are captured only while the synchronized SMM-active is inactive. Changes made during a session have no effect on steering.
- R11: exit_flush_busy is high after edges 2 through 2+PULSE_CLKS of an exit that issues a flush. While it is high, both chip selects are low.
- R12: During and right after reset, flush_n is high, exit_flush_busy is low, and SMM is treated as inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smi_act_n | input | 1 | SMM-active from CPU, active low, asynchronous |
| cache_en_n | input | 1 | Cache-enable from system, active low; sampled during entry flush |
| cfg_overlay | input | 1 | 1 = SMRAM overlays main memory, 0 = separate window |
| cfg_base | input | ADDR_W | SMRAM window base (low WIN_LG bits ignored) |
| mem_req | input | 1 | A memory cycle is present |
| mem_from_cpu | input | 1 | The cycle comes from the CPU |
| mem_addr | input | ADDR_W | Byte address of the cycle |
| smram_cs | output | 1 | SMRAM chip select, active high |
| main_cs | output | 1 | Main memory chip select, active high |
| flush_n | output | 1 | Cache flush request to CPU and second-level cache, active low |
| exit_flush_busy | output | 1 | Exit flush pending or in progress |

## Verification
A wrong synchronizer depth or edge detector shifts the flush window by whole cycles, so the bench compares flush_n and exit_flush_busy edge by edge after each SMM-active transition. A corrupted cache-disabled flag shows up at the next exit as a missing or extra flush, or, if it is not cleared, at the exit of the session after it. A configuration register that is not frozen changes which chip select fires within one cycle of the input change inside a session. The steering decode is checked on every cycle of the random phases.

// File: rtl/smm_steer_pkg.sv
package smm_steer_pkg;
   typedef enum logic [1:0] {
      FL_IDLE  = 2'd0,
      FL_ENTRY = 2'd1,
      FL_EXIT  = 2'd2
   } flush_kind_e;
endpackage

// File: rtl/smm_sync.sv
module smm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic level_n,
   output logic fall,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("smm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '1;
         prev_n <= 1'b1;
      end else begin
         chain  <= {chain[STAGES-2:0], async_n};
         prev_n <= chain[STAGES-1];
      end
   end

   assign level_n = chain[STAGES-1];
   assign fall    = prev_n & ~level_n;
   assign rise    = ~prev_n & level_n;

   assert_edge_follows_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fall |-> !$past(chain[0]));
endmodule

// File: rtl/smm_win_dec.sv
module smm_win_dec #(
   parameter int ADDR_W = 32,
   parameter int WIN_LG = 15
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   output logic              hit
);
   generate
      if (WIN_LG >= ADDR_W) begin : g_bad
         $error("smm_win_dec: WIN_LG must be below ADDR_W");
      end else if (WIN_LG == 0) begin : g_exact
         assign hit = (addr == base);
      end else begin : g_slice
         assign hit = (addr[ADDR_W-1:WIN_LG] == base[ADDR_W-1:WIN_LG]);
      end
   endgenerate
endmodule

// File: rtl/smm_flush_seq.sv
module smm_flush_seq
   import smm_steer_pkg::*;
#(
   parameter int PULSE_CLKS = 2,
   localparam int CW = $clog2(PULSE_CLKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall,
   input  logic rise,
   input  logic overlay,
   input  logic cache_en_n,
   output logic flush_n,
   output logic exit_busy
);
   generate
      if (PULSE_CLKS < 1) begin : g_bad
         $error("smm_flush_seq: PULSE_CLKS must be at least 1");
      end
   endgenerate

   localparam logic [CW-1:0] LOAD = CW'(PULSE_CLKS);

   logic [CW-1:0] cnt;
   flush_kind_e   kind;
   logic          cache_off;
   logic          start_entry, start_exit;

   assign start_entry = fall & overlay;
   assign start_exit  = rise & overlay & ~cache_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         kind      <= FL_IDLE;
         cache_off <= 1'b0;
      end else begin
         if (fall)
            cache_off <= 1'b0;
         else if (cnt != '0 && kind == FL_ENTRY && cache_en_n)
            cache_off <= 1'b1;

         if (start_entry) begin
            cnt  <= LOAD;
            kind <= FL_ENTRY;
         end else if (start_exit) begin
            cnt  <= LOAD;
            kind <= FL_EXIT;
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) kind <= FL_IDLE;
         end
      end
   end

   assign flush_n   = (cnt == '0);
   assign exit_busy = (kind == FL_EXIT) | start_exit;

   assert_flush_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flush_n) |-> $past(fall || rise));
   assert_no_flush_separate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flush_n) |-> $past(overlay));
   assert_exit_skip_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && cache_off) |=> !(kind == FL_EXIT && $fell(flush_n)));
endmodule

// File: rtl/smm_mem_steer.sv
module smm_mem_steer #(
   parameter int ADDR_W      = 32,
   parameter int WIN_LG      = 15,
   parameter int PULSE_CLKS  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smi_act_n,
   input  logic              cache_en_n,
   input  logic              cfg_overlay,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              mem_req,
   input  logic              mem_from_cpu,
   input  logic [ADDR_W-1:0] mem_addr,
   output logic              smram_cs,
   output logic              main_cs,
   output logic              flush_n,
   output logic              exit_flush_busy
);
   logic              smm_level_n, smm_fall, smm_rise;
   logic              ovl_q;
   logic [ADDR_W-1:0] base_q;
   logic              win_hit;

   smm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_n(smi_act_n),
      .level_n(smm_level_n), .fall(smm_fall), .rise(smm_rise));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovl_q  <= 1'b1;
         base_q <= '0;
      end else if (smm_level_n) begin
         ovl_q  <= cfg_overlay;
         base_q <= cfg_base;
      end
   end

   smm_win_dec #(.ADDR_W(ADDR_W), .WIN_LG(WIN_LG)) u_dec (
      .addr(mem_addr), .base(base_q), .hit(win_hit));

   smm_flush_seq #(.PULSE_CLKS(PULSE_CLKS)) u_flush (
      .clk(clk), .rst_n(rst_n), .fall(smm_fall), .rise(smm_rise),
      .overlay(ovl_q), .cache_en_n(cache_en_n),
      .flush_n(flush_n), .exit_busy(exit_flush_busy));

   always_comb begin
      smram_cs = 1'b0;
      main_cs  = 1'b0;
      if (mem_req && !exit_flush_busy) begin
         if (!win_hit)
            main_cs = 1'b1;
         else if (!smm_level_n && mem_from_cpu)
            smram_cs = 1'b1;
         else if (ovl_q)
            main_cs = 1'b1;
      end
   end

   assert_cs_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({smram_cs, main_cs}));
   assert_smram_cpu_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      smram_cs |-> (mem_from_cpu && mem_req && !smm_level_n));
   assert_busy_blocks_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      exit_flush_busy |-> (!smram_cs && !main_cs));
   assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!smm_level_n && !$past(smm_level_n)) |-> ($stable(ovl_q) && $stable(base_q)));
endmodule

// File: tb/tb_smm_mem_steer.sv
`timescale 1ns/100ps
module tb_smm_mem_steer;
   localparam int AW = 32;
   localparam int P  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smi_act_n = 1'b1, cache_en_n = 1'b0, cfg_overlay = 1'b1;
   logic [AW-1:0] cfg_base = 32'h38000;
   logic mem_req = 1'b0, mem_from_cpu = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic smram_cs, main_cs, flush_n, exit_flush_busy;

   int total = 0, bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   smm_mem_steer dut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_cs(input logic [AW-1:0] a, input logic cpu,
         input logic req, input bit smm, input bit ovl, input logic [AW-1:0] base);
      bit hit = (a[AW-1:15] == base[AW-1:15]);
      if (!req) return 2'b00;
      if (!hit) return 2'b01;
      if (smm && cpu) return 2'b10;
      return ovl ? 2'b01 : 2'b00;
   endfunction

   task automatic steer(input logic [AW-1:0] a, input logic cpu, input logic req,
         input bit smm, input bit ovl, input logic [AW-1:0] base, input string req_tag);
      logic [1:0] e;
      @(negedge clk);
      mem_addr = a; mem_from_cpu = cpu; mem_req = req;
      #1;
      e = exp_cs(a, cpu, req, smm, ovl, base);
      chk({smram_cs, main_cs} == e, req_tag, {smram_cs, main_cs}, e);
   endtask

   task automatic random_steer(input int n, input bit smm, input bit ovl, input logic [AW-1:0] base);
      for (int i = 0; i < n; i++) begin
         logic [AW-1:0] a;
         a = (($urandom % 4) == 0) ? $urandom : (base - 32'h4000 + ($urandom % 32'h10000));
         steer(a, 1'($urandom), 1'(($urandom % 5) != 0), smm, ovl, base, "R2/R3/R4/R5 random");
      end
   endtask

   // drive SMM-active to lvl; check flush_n, exit_flush_busy and main_cs edge by edge
   task automatic edge_seq(input logic lvl, input bit flush_exp, input bit busy_exp, input string tag);
      @(negedge clk);
      mem_req = 1'b1; mem_from_cpu = 1'b1; mem_addr = 32'h100;
      smi_act_n = lvl;
      for (int i = 1; i <= P + 5; i++) begin
         bit fl, bz;
         @(posedge clk); #1;
         fl = flush_exp && i >= 3 && i <= 2 + P;
         bz = busy_exp && i >= 2 && i <= 2 + P;
         chk(flush_n == !fl, tag, flush_n, !fl);
         chk(exit_flush_busy == bz, "R11 busy", exit_flush_busy, bz);
         chk(main_cs == !bz, "R11 cs hold", main_cs, !bz);
      end
   endtask

   initial begin
      void'($urandom(32'h5a17));
      #1;
      chk(flush_n == 1'b1, "R12 flush_n in reset", flush_n, 1);
      chk(exit_flush_busy == 1'b0, "R12 busy in reset", exit_flush_busy, 0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk(flush_n == 1'b1 && exit_flush_busy == 1'b0, "R12 after reset", {flush_n, exit_flush_busy}, 2'b10);

      // overlaid, outside SMM
      steer(32'h37FFF, 1, 1, 0, 1, 32'h38000, "R1 below window");
      steer(32'h38000, 1, 1, 0, 1, 32'h38000, "R1/R3 window low outside SMM");
      steer(32'h3FFFF, 1, 1, 0, 1, 32'h38000, "R1/R3 window high outside SMM");
      steer(32'h40000, 1, 1, 0, 1, 32'h38000, "R1/R4 above window");
      steer(32'h38000, 1, 0, 0, 1, 32'h38000, "R4 no request");
      random_steer(40, 0, 1, 32'h38000);

      // entry with caching on
      edge_seq(1'b0, 1, 0, "R6 entry flush");
      steer(32'h38000, 1, 1, 1, 1, 32'h38000, "R2 window low in SMM");
      steer(32'h3FFFF, 1, 1, 1, 1, 32'h38000, "R2 window high in SMM");
      steer(32'h3A000, 0, 1, 1, 1, 32'h38000, "R3 non-CPU in SMM");
      steer(32'h40000, 1, 1, 1, 1, 32'h38000, "R4 outside in SMM");
      random_steer(40, 1, 1, 32'h38000);

      // configuration change during the session has no effect
      @(negedge clk) begin cfg_overlay = 1'b0; cfg_base = 32'h10000; end
      repeat (2) @(posedge clk);
      steer(32'h3A000, 0, 1, 1, 1, 32'h38000, "R10 overlay frozen");
      steer(32'h10000, 1, 1, 1, 1, 32'h38000, "R10 base frozen");
      @(negedge clk) begin cfg_overlay = 1'b1; cfg_base = 32'h38000; end

      edge_seq(1'b1, 1, 1, "R7 exit flush");

      // cache disabled during entry flush: no exit flush
      @(negedge clk) cache_en_n = 1'b1;
      edge_seq(1'b0, 1, 0, "R6 entry flush 2");
      @(negedge clk) cache_en_n = 1'b0;
      edge_seq(1'b1, 0, 0, "R8 exit suppressed");

      // flag cleared by the next session
      edge_seq(1'b0, 1, 0, "R6 entry flush 3");
      edge_seq(1'b1, 1, 1, "R8 flag cleared, R7 exit flush");

      // non-overlaid layout
      @(negedge clk) begin cfg_overlay = 1'b0; cfg_base = 32'h80000; end
      repeat (3) @(posedge clk);
      steer(32'h80000, 1, 1, 0, 0, 32'h80000, "R5 window outside SMM");
      edge_seq(1'b0, 0, 0, "R9 no entry flush");
      steer(32'h80000, 1, 1, 1, 0, 32'h80000, "R5 CPU window in SMM");
      steer(32'h87FFF, 0, 1, 1, 0, 32'h80000, "R5 non-CPU window in SMM");
      random_steer(40, 1, 0, 32'h80000);
      edge_seq(1'b1, 0, 0, "R9 no exit flush");
      random_steer(30, 0, 0, 32'h80000);

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule